// File: doc/BRIEF.md
# Linear Framebuffer Window Decoder

This block places two host-visible windows for a display controller: a linear framebuffer window and a 256-byte window of memory-mapped control registers. It takes the host bus type, a programmable base for the PCI case, the chip revision and two sequencer control bits. From these it builds a window map. The window map is held in registers and is reloaded only on a recompute strobe. Any host address presented on `bus_addr` is then classified, combinationally against the held map, as a linear hit, a register hit, or neither.

The register window lives in one of two places. It can sit at a fixed legacy location, or it can move into the top 256 bytes of the linear window. In the second case, on small windows, the linear window gives up those 256 bytes. On large windows no separate register window is decoded and the whole range stays linear, because register decoding is left to the linear data path.

The block also stores the graphics memory-map register. A write to that register raises the recompute strobe only when its memory-map select field changes.

Top module: `lfb_window_decoder`

## Requirements
- R1: The window base depends on `bus_kind` (2'b00 = PCI, 2'b01 = local bus, 2'b10 or 2'b11 = other bus). On PCI it is `pci_base` with the bits below the window size cleared. On the local bus it is 0x0800_0000 (128 MiB). On the other bus it is 0x00E0_0000.
- R2: On PCI and on the local bus, the full window size is 16 MiB when `chip_rev` equals 8'h3A and 4 MiB for any other revision. On the other bus it is 2 MiB.
- R3: With `seq_reg_en` = 0, `reg_hit` is never asserted and `win_size` equals the full size.
- R4: With `seq_reg_en` = 1 and `seq_reg_tail` = 0, `reg_hit` is asserted exactly for addresses 0x000B_8000 to 0x000B_80FF.
- R5: With both `seq_reg_en` and `seq_reg_tail` set, and a full size below 4 MiB, `reg_hit` covers the last 256 bytes of the full window, and `win_size` is the full size minus 256.
- R6: With both bits set and a full size of 4 MiB or more, `reg_hit` is never asserted and `win_size` is the full size.
- R7: A write on `gr6_we` always stores `gr6_wdata` into `gr6_q`, which is visible on the next cycle. The write raises `remap_o` in its own cycle only if bits 3:2 of the new value differ from bits 3:2 of `gr6_q`.
- R8: `remap_o` is high in any cycle where the configuration inputs differ from the values they had in the previous cycle. It is also high in the first cycle after reset. It is low when neither this nor R7 applies.
- R9: The map moves only at the clock edge that ends a cycle with `remap_o` high. During the strobe cycle the old map is still in use, and from the next cycle the new map decodes.
- R10: `lin_hit` is asserted for addresses from `win_base` up to `win_base + win_size - 1`, except where `reg_hit` is asserted. The register window wins, so the two hits are never high together.
- R11: While reset is asserted, `win_base` and `win_size` are 0, neither hit is asserted, and `gr6_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_kind | input | 2 | Host bus type: 0 PCI, 1 local bus, 2 or 3 other |
| pci_base | input | ADDR_W | Programmed linear base used on PCI |
| chip_rev | input | REV_W | Chip revision code |
| seq_reg_en | input | 1 | Enables the register window |
| seq_reg_tail | input | 1 | Places the register window at the tail of the linear window |
| gr6_we | input | 1 | Write strobe for the graphics memory-map register |
| gr6_wdata | input | 8 | Write data for that register |
| bus_addr | input | ADDR_W | Host address to classify |
| gr6_q | output | 8 | Stored graphics memory-map register |
| remap_o | output | 1 | Recompute strobe; the map reloads at the end of this cycle |
| win_base | output | ADDR_W | Base of the linear window in use |
| win_size | output | ADDR_W | Byte length of the linear window in use |
| lin_hit | output | 1 | `bus_addr` falls in the linear window |
| reg_hit | output | 1 | `bus_addr` falls in the register window |

## Verification
A stale or corrupted map register shows up on `win_base` and `win_size` in the cycle right after the strobe, and at the hit outputs as soon as an address near a window edge is presented. The sweep probes both sides of every edge for each combination of bus type, revision and the two sequencer bits. A wrong change detector shows up in the strobe cycle itself, either as a missing or extra `remap_o` or as an early change of the map. A wrong stored register value appears on `gr6_q` one cycle after the write.

// File: rtl/lfbw_pkg.sv
`timescale 1ns/1ps
package lfbw_pkg;
   localparam logic [1:0] BK_PCI   = 2'd0;
   localparam logic [1:0] BK_LOCAL = 2'd1;

   typedef enum logic [1:0] {
      RM_NONE   = 2'd0,
      RM_LEGACY = 2'd1,
      RM_TAIL   = 2'd2
   } reg_mode_e;
endpackage

// File: rtl/lfbw_map_calc.sv
`timescale 1ns/1ps
module lfbw_map_calc
   import lfbw_pkg::*;
#(
   parameter int unsigned ADDR_W          = 32,
   parameter int unsigned REV_W           = 8,
   parameter int unsigned TOP_REV         = 8'h3A,
   parameter int unsigned LOCAL_BASE      = 32'h0800_0000,
   parameter int unsigned OTHER_BASE      = 32'h00E0_0000,
   parameter int unsigned LEGACY_BASE     = 32'h000B_8000,
   parameter int unsigned BIG_LOG2        = 24,
   parameter int unsigned STD_LOG2        = 22,
   parameter int unsigned OTHER_LOG2      = 21,
   parameter int unsigned TAIL_LIMIT_LOG2 = 22,
   parameter int unsigned REG_LOG2        = 8,
   parameter bit          LEGACY_EN       = 1'b1
) (
   input  logic [1:0]        bus_kind,
   input  logic [ADDR_W-1:0] pci_base,
   input  logic [REV_W-1:0]  chip_rev,
   input  logic              reg_en,
   input  logic              reg_tail,
   output logic [ADDR_W-1:0] nxt_base,
   output logic [ADDR_W-1:0] nxt_len,
   output logic [ADDR_W-1:0] nxt_reg_base,
   output reg_mode_e         nxt_mode
);
   localparam logic [ADDR_W-1:0] BIG_FULL   = ADDR_W'(1) << BIG_LOG2;
   localparam logic [ADDR_W-1:0] STD_FULL   = ADDR_W'(1) << STD_LOG2;
   localparam logic [ADDR_W-1:0] OTHER_FULL = ADDR_W'(1) << OTHER_LOG2;
   localparam logic [ADDR_W-1:0] TAIL_LIMIT = ADDR_W'(1) << TAIL_LIMIT_LOG2;
   localparam logic [ADDR_W-1:0] REG_BYTES  = ADDR_W'(1) << REG_LOG2;

   logic              legacy_ok;
   logic [ADDR_W-1:0] full;

   generate
      if (LEGACY_EN) begin : g_legacy
         assign legacy_ok = 1'b1;
      end else begin : g_no_legacy
         assign legacy_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      if (bus_kind == BK_PCI || bus_kind == BK_LOCAL)
         full = (chip_rev == REV_W'(TOP_REV)) ? BIG_FULL : STD_FULL;
      else
         full = OTHER_FULL;

      case (bus_kind)
         BK_PCI:   nxt_base = pci_base & ~(full - ADDR_W'(1));
         BK_LOCAL: nxt_base = ADDR_W'(LOCAL_BASE);
         default:  nxt_base = ADDR_W'(OTHER_BASE);
      endcase

      if (!reg_en)
         nxt_mode = RM_NONE;
      else if (!reg_tail)
         nxt_mode = legacy_ok ? RM_LEGACY : RM_NONE;
      else if (full < TAIL_LIMIT)
         nxt_mode = RM_TAIL;
      else
         nxt_mode = RM_NONE;

      nxt_len      = (nxt_mode == RM_TAIL) ? full - REG_BYTES : full;
      nxt_reg_base = (nxt_mode == RM_TAIL) ? nxt_base + nxt_len
                                           : ADDR_W'(LEGACY_BASE);
   end
endmodule

// File: rtl/lfbw_range_hit.sv
`timescale 1ns/1ps
module lfbw_range_hit #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] lo,
   input  logic [ADDR_W-1:0] len,
   output logic              hit
);
   logic [ADDR_W-1:0] offs;
   assign offs = addr - lo;
   assign hit  = en && (offs < len);
endmodule

// File: rtl/lfbw_remap_ctl.sv
`timescale 1ns/1ps
module lfbw_remap_ctl #(
   parameter int unsigned CFG_W  = 44,
   parameter int unsigned SEL_LO = 2,
   parameter int unsigned SEL_HI = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CFG_W-1:0] cfg,
   input  logic             gr6_we,
   input  logic [7:0]       gr6_wdata,
   output logic [7:0]       gr6_q,
   output logic             remap
);
   logic [CFG_W-1:0] snap;
   logic             snap_valid;
   logic             sel_change;

   assign sel_change = gr6_we && (gr6_wdata[SEL_HI:SEL_LO] != gr6_q[SEL_HI:SEL_LO]);
   assign remap      = !snap_valid || (cfg != snap) || sel_change;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap       <= '0;
         snap_valid <= 1'b0;
         gr6_q      <= '0;
      end else begin
         snap       <= cfg;
         snap_valid <= 1'b1;
         if (gr6_we) gr6_q <= gr6_wdata;
      end
   end

   a_r7_gr6_store: assert property (@(posedge clk) disable iff (!rst_n)
      gr6_we |=> (gr6_q == $past(gr6_wdata)));
endmodule

// File: rtl/lfb_window_decoder.sv
`timescale 1ns/1ps
module lfb_window_decoder
   import lfbw_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned REV_W       = 8,
   parameter int unsigned TOP_REV     = 8'h3A,
   parameter int unsigned LOCAL_BASE  = 32'h0800_0000,
   parameter int unsigned OTHER_BASE  = 32'h00E0_0000,
   parameter int unsigned LEGACY_BASE = 32'h000B_8000,
   parameter int unsigned BIG_LOG2    = 24,
   parameter int unsigned STD_LOG2    = 22,
   parameter int unsigned OTHER_LOG2  = 21,
   parameter int unsigned REG_LOG2    = 8,
   parameter bit          LEGACY_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_kind,
   input  logic [ADDR_W-1:0] pci_base,
   input  logic [REV_W-1:0]  chip_rev,
   input  logic              seq_reg_en,
   input  logic              seq_reg_tail,
   input  logic              gr6_we,
   input  logic [7:0]        gr6_wdata,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [7:0]        gr6_q,
   output logic              remap_o,
   output logic [ADDR_W-1:0] win_base,
   output logic [ADDR_W-1:0] win_size,
   output logic              lin_hit,
   output logic              reg_hit
);
   localparam int unsigned       CFG_W     = 2 + ADDR_W + REV_W + 2;
   localparam logic [ADDR_W-1:0] REG_BYTES = ADDR_W'(1) << REG_LOG2;

   generate
      if (ADDR_W > 32 || ADDR_W <= BIG_LOG2 || ADDR_W < 28)
         $error("ADDR_W must hold the 128 MiB base and the largest window");
      if (REG_LOG2 >= OTHER_LOG2 || OTHER_LOG2 > STD_LOG2 || STD_LOG2 > BIG_LOG2)
         $error("window size parameters out of order");
   endgenerate

   logic [ADDR_W-1:0] nxt_base, nxt_len, nxt_reg_base;
   reg_mode_e         nxt_mode;
   logic [ADDR_W-1:0] reg_base_q;
   reg_mode_e         mode_q;
   logic              lin_raw, reg_raw;

   lfbw_map_calc #(
      .ADDR_W(ADDR_W), .REV_W(REV_W), .TOP_REV(TOP_REV),
      .LOCAL_BASE(LOCAL_BASE), .OTHER_BASE(OTHER_BASE), .LEGACY_BASE(LEGACY_BASE),
      .BIG_LOG2(BIG_LOG2), .STD_LOG2(STD_LOG2), .OTHER_LOG2(OTHER_LOG2),
      .TAIL_LIMIT_LOG2(STD_LOG2), .REG_LOG2(REG_LOG2), .LEGACY_EN(LEGACY_EN)
   ) i_calc (
      .bus_kind(bus_kind), .pci_base(pci_base), .chip_rev(chip_rev),
      .reg_en(seq_reg_en), .reg_tail(seq_reg_tail),
      .nxt_base(nxt_base), .nxt_len(nxt_len),
      .nxt_reg_base(nxt_reg_base), .nxt_mode(nxt_mode)
   );

   lfbw_remap_ctl #(.CFG_W(CFG_W)) i_ctl (
      .clk(clk), .rst_n(rst_n),
      .cfg({bus_kind, pci_base, chip_rev, seq_reg_en, seq_reg_tail}),
      .gr6_we(gr6_we), .gr6_wdata(gr6_wdata),
      .gr6_q(gr6_q), .remap(remap_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_base   <= '0;
         win_size   <= '0;
         reg_base_q <= '0;
         mode_q     <= RM_NONE;
      end else if (remap_o) begin
         win_base   <= nxt_base;
         win_size   <= nxt_len;
         reg_base_q <= nxt_reg_base;
         mode_q     <= nxt_mode;
      end
   end

   lfbw_range_hit #(.ADDR_W(ADDR_W)) i_lin (
      .en(1'b1), .addr(bus_addr), .lo(win_base), .len(win_size), .hit(lin_raw)
   );

   lfbw_range_hit #(.ADDR_W(ADDR_W)) i_reg (
      .en(mode_q != RM_NONE), .addr(bus_addr), .lo(reg_base_q),
      .len(REG_BYTES), .hit(reg_raw)
   );

   assign reg_hit = reg_raw;
   assign lin_hit = lin_raw && !reg_raw;

   a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(lin_hit && reg_hit));

   a_r9_map_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !remap_o |=> ($stable(win_base) && $stable(win_size)));

   a_r3_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (remap_o && !seq_reg_en) |=> !reg_hit);

   a_r6_big_no_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (remap_o && seq_reg_tail && bus_kind == BK_PCI &&
       chip_rev == REV_W'(TOP_REV)) |=> !reg_hit);
endmodule

// File: tb/test_lfb_window_decoder.sv
`timescale 1ns/1ps
module test_lfb_window_decoder;
   localparam logic [7:0] TOP = 8'h3A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_kind = 2'd0;
   logic [31:0] pci_base = 32'h0;
   logic [7:0]  chip_rev = 8'h00;
   logic        seq_reg_en = 1'b0;
   logic        seq_reg_tail = 1'b0;
   logic        gr6_we = 1'b0;
   logic [7:0]  gr6_wdata = 8'h00;
   logic [31:0] bus_addr = 32'h0;
   logic [7:0]  gr6_q;
   logic        remap_o;
   logic [31:0] win_base, win_size;
   logic        lin_hit, reg_hit;

   int total = 0;
   int bad = 0;
   logic [31:0] cur_base = 32'h0;
   logic [31:0] cur_len  = 32'h0;
   logic [31:0] cur_regb = 32'h0;
   int          cur_mode = 0;   // 0 none, 1 legacy, 2 tail
   logic        cur_en = 1'b0;

   always #10 clk = ~clk;

   lfb_window_decoder i_lfb_window_decoder (
      .clk(clk), .rst_n(rst_n), .bus_kind(bus_kind), .pci_base(pci_base),
      .chip_rev(chip_rev), .seq_reg_en(seq_reg_en), .seq_reg_tail(seq_reg_tail),
      .gr6_we(gr6_we), .gr6_wdata(gr6_wdata), .bus_addr(bus_addr),
      .gr6_q(gr6_q), .remap_o(remap_o), .win_base(win_base), .win_size(win_size),
      .lin_hit(lin_hit), .reg_hit(reg_hit)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", what, act, exp);
      end
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   task automatic probe(input logic [31:0] a);
      logic  er, el;
      string rt;
      bus_addr = a;
      #1;
      er = (cur_mode != 0) && ((a - cur_regb) < 32'd256);
      el = !er && ((a - cur_base) < cur_len);
      if (!cur_en)            rt = "R3";
      else if (cur_mode == 1) rt = "R4";
      else if (cur_mode == 2) rt = "R5";
      else                    rt = "R6";
      chk({31'd0, reg_hit}, {31'd0, er}, $sformatf("%s reg_hit addr=%h", rt, a));
      chk({31'd0, lin_hit}, {31'd0, el}, $sformatf("R10 lin_hit addr=%h", a));
   endtask

   task automatic apply(input logic [1:0] k, input logic [7:0] rv, input logic e,
                        input logic t, input logic [31:0] pb);
      logic [31:0] full, nb;
      @(negedge clk);
      bus_kind = k; chip_rev = rv; seq_reg_en = e; seq_reg_tail = t; pci_base = pb;
      #1;
      chk({31'd0, remap_o}, 32'd1, "R8 strobe on config change");
      chk(win_base, cur_base, "R9 old base during strobe");
      chk(win_size, cur_len, "R9 old size during strobe");
      full = (k < 2) ? ((rv == TOP) ? 32'h0100_0000 : 32'h0040_0000) : 32'h0020_0000;
      if (k == 2'd0)      nb = pb & ~(full - 32'd1);
      else if (k == 2'd1) nb = 32'h0800_0000;
      else                nb = 32'h00E0_0000;
      cur_en = e;
      if (!e)                        cur_mode = 0;
      else if (!t)                   cur_mode = 1;
      else if (full < 32'h0040_0000) cur_mode = 2;
      else                           cur_mode = 0;
      cur_base = nb;
      cur_len  = (cur_mode == 2) ? full - 32'd256 : full;
      cur_regb = (cur_mode == 2) ? nb + full - 32'd256 : 32'h000B_8000;
      @(negedge clk);
      #1;
      chk({31'd0, remap_o}, 32'd0, "R8 strobe low with steady config");
      chk(win_base, cur_base, "R1 window base");
      chk(win_size, cur_len, (cur_mode == 2) ? "R5 shrunk size" : "R2 window size");
      probe(nb);
      probe(nb - 32'd1);
      probe(nb + full - 32'd257);
      probe(nb + full - 32'd256);
      probe(nb + full - 32'd1);
      probe(nb + full);
      probe(32'h000B_7FFF);
      probe(32'h000B_8000);
      probe(32'h000B_80FF);
      probe(32'h000B_8100);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(win_base, 32'h0, "R11 reset base");
      chk(win_size, 32'h0, "R11 reset size");
      chk({31'd0, lin_hit}, 32'd0, "R11 reset lin_hit");
      chk({31'd0, reg_hit}, 32'd0, "R11 reset reg_hit");
      chk({24'd0, gr6_q}, 32'h0, "R11 reset gr6");
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk({31'd0, remap_o}, 32'd1, "R8 strobe in first cycle after reset");
      @(negedge clk);
      #1;
      chk({31'd0, remap_o}, 32'd0, "R8 no strobe once settled");
      cur_base = win_base;   // initial config: PCI, rev 0, base 0
      chk(win_base, 32'h0, "R1 initial PCI base");
      chk(win_size, 32'h0040_0000, "R2 initial size");
      cur_len = 32'h0040_0000;

      for (int k = 0; k < 3; k++)
         for (int r = 0; r < 2; r++)
            for (int e = 0; e < 2; e++)
               for (int t = 0; t < 2; t++)
                  apply(2'(k), (r == 0) ? TOP : 8'h21, 1'(e), 1'(t), 32'hE345_6789);

      // R10: legacy register window inside a linear window based at zero
      apply(2'd0, 8'h21, 1'b1, 1'b0, 32'h0000_0000);
      // R2: a different programmed base on PCI with the top revision
      apply(2'd0, TOP, 1'b1, 1'b1, 32'h1234_5678);

      // R7: same select bits, no strobe, value still stored
      @(negedge clk);
      gr6_we = 1'b1; gr6_wdata = 8'h03;
      #1;
      chk({31'd0, remap_o}, 32'd0, "R7 no strobe when bits 3:2 unchanged");
      @(negedge clk);
      gr6_we = 1'b0;
      #1;
      chk({24'd0, gr6_q}, 32'h03, "R7 value stored without strobe");
      // R7: changed select bits raise the strobe
      @(negedge clk);
      gr6_we = 1'b1; gr6_wdata = 8'h0B;
      #1;
      chk({31'd0, remap_o}, 32'd1, "R7 strobe when bits 3:2 change");
      @(negedge clk);
      gr6_we = 1'b0;
      #1;
      chk({24'd0, gr6_q}, 32'h0B, "R7 value stored with strobe");
      chk({31'd0, remap_o}, 32'd0, "R7 strobe lasts one cycle");
      chk(win_base, cur_base, "R9 map unchanged by same-config remap");
      @(negedge clk);
      gr6_we = 1'b1; gr6_wdata = 8'hFB;
      #1;
      chk({31'd0, remap_o}, 32'd0, "R7 other bits ignored for strobe");
      @(negedge clk);
      gr6_we = 1'b0;
      #1;
      chk({24'd0, gr6_q}, 32'hFB, "R7 stored upper bits");

      summary();
      $finish;
   end
endmodule